// File: doc/BRIEF.md
# Multiplexed ADC Control Interface

This block is the register front end of a 10-bit converter that can be pointed at one of eight input words. Software programs a control word holding an enable flag, an input selector, a reference choice, a bypass flag, a sync-enable flag and a start flag. It then reads a result word whose top bit says whether the value in the low ten bits is fresh. The analog part is modelled by digital sample words on an input bus. The converter's busy time is a parameter counted in clock cycles.

A conversion is requested the way a driver would do it. First the control word is written without start, then the same word is written with start set. Only that rising start edge, carried by a word that also has enable set, launches a conversion. When sync enable is set, the launch waits for an external strobe before the input is sampled. On completion the result is loaded, its valid bit rises and a single-cycle event is sent toward an interrupt unit. Writing a control word with enable clear stops any pending or running conversion.

Top module: `adc_ctrl_if`

## Requirements
- R1: After reset the control register reads 0x0000, the data register reads 0x0000 and `conv_done` is low.
- R2: The control register at address 0x66 keeps the written bits 15, 7, 5, 4:2, 1 and 0 and reads bits 14:8 and 6 as zero (mask 0x80BF). Any address other than 0x66 and 0x68 reads as zero.
- R3: The data register at address 0x68 returns the valid flag in bit 15 and the result in bits 9:0. Bits 14:10 read as zero.
- R4: A conversion is launched only by a control write whose word has bit 15 (enable) and bit 7 (start) set while the stored start bit is 0. Writing start = 1 again while it is already 1 launches nothing.
- R5: A start edge carried by a word with enable clear launches nothing, but the start bit is still stored.
- R6: Bits 4:2 select input code i, which is `samp_in[i*10 +: 10]`. The selected word is captured when the conversion begins, so later changes on `samp_in` do not alter the result.
- R7: With sync enable (bit 0) clear, the sampling edge is the triggering write edge. On the clock edge LAT cycles after the sampling edge, the result and valid are loaded and `conv_done` is high for exactly one cycle.
- R8: The valid flag clears on the triggering edge and stays clear until the result loads. It then stays set, with an unchanged result, until the next triggering edge.
- R9: With sync enable set, the conversion waits with no result until `sync_strobe` is sampled high on a later edge. That edge is the sampling edge, and R7's latency counts from it.
- R10: A start edge that arrives while a conversion is waiting for the strobe or is running is ignored. The running conversion finishes with its own sample at its own time.
- R11: A control write with enable clear abandons a waiting or running conversion. No `conv_done` pulse follows, and valid stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| samp_in | input | 80 | Eight 10-bit sample words, word i at bits i*10+9:i*10 |
| sync_strobe | input | 1 | External sampling strobe used when sync enable is set |
| conv_done | output | 1 | One-cycle conversion-complete event |

## Verification
Some properties are checked on every clock cycle:
- a triggering write stores both enable and start;
- the busy counter steps down by one each cycle;
- a sync wait persists until the strobe;
- an abort returns the sequencer to idle with no event;
- the event lasts a single cycle;
- the result register changes only alongside the event.

The bench's scenarios are needed for the rest:
- the selected input value and its capture moment;
- the exact completion cycle;
- that repeated start or disabled start writes produce nothing;
- that a start during a busy conversion leaves its sample and timing intact.

Random conversions over all selectors, sync modes and strobe delays are mixed with these directed cases.

// File: rtl/adcif_pkg.sv
// Package: shared addresses, control-field positions and sequencer states
// for the multiplexed ADC control interface. Assumes a 16-bit register bus.
package adcif_pkg;
    localparam int           REG_W     = 16;
    localparam int           ADDR_W    = 8;
    localparam int           SEL_W     = 3;
    localparam logic [7:0]   CTRL_ADDR = 8'h66;
    localparam logic [7:0]   DATA_ADDR = 8'h68;
    localparam int           EN_B      = 15;
    localparam int           GO_B      = 7;
    localparam int           SEL_LSB   = 2;
    localparam int           SYNC_B    = 0;
    localparam int           VALID_B   = 15;
    localparam logic [15:0]  CTRL_MASK = 16'h80BF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BUSY = 2'd2
    } conv_st_e;
endpackage

// File: rtl/adcif_ctrl_reg.sv
// Control register with start-edge detection.
// Stores the implemented control bits on every write to the control address.
// Flags a trigger when the written word has enable and start set and the
// stored start bit is 0. Flags an abort when a control write clears enable.
// Assumes bus_wr is a single-cycle strobe per write.
module adcif_ctrl_reg
    import adcif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  ctrl_q,
    output logic              trig,
    output logic [SEL_W-1:0]  trig_sel,
    output logic              trig_sync,
    output logic              abort
);
    logic ctrl_wr;

    // Decode a write to the control register and derive trigger/abort.
    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == CTRL_ADDR);
        trig      = ctrl_wr && bus_wdata[EN_B] && bus_wdata[GO_B] && !ctrl_q[GO_B];
        abort     = ctrl_wr && !bus_wdata[EN_B];
        trig_sel  = bus_wdata[SEL_LSB +: SEL_W];
        trig_sync = bus_wdata[SYNC_B];
    end

    // Hold the implemented control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
        end
    end

    AST_TRIG_STORES_EN_GO: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (ctrl_q[EN_B] && ctrl_q[GO_B])); // R4
endmodule

// File: rtl/adcif_in_mux.sv
// Input selector: picks one of N_IN sample words by code.
// Codes with no matching input return zero. Purely combinational.
module adcif_in_mux #(
    parameter int N_IN   = 8,
    parameter int SAMP_W = 10,
    parameter int SEL_W  = 3
) (
    input  logic [N_IN*SAMP_W-1:0] samp_in,
    input  logic [SEL_W-1:0]       sel,
    output logic [SAMP_W-1:0]      samp_out
);
    logic [SAMP_W-1:0] words [N_IN];

    for (genvar g = 0; g < N_IN; g++) begin : g_split
        assign words[g] = samp_in[g*SAMP_W +: SAMP_W];
    end

    // Select the addressed word, zero when the code has no input.
    always_comb begin
        samp_out = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (int'(sel) == i) samp_out = words[i];
        end
    end
endmodule

// File: rtl/adcif_conv_seq.sv
// Conversion sequencer. From idle, a trigger either samples at once or
// waits for the sync strobe. It then counts LAT cycles, loads the result,
// sets valid and emits a one-cycle done event. An abort returns it to idle.
// Triggers outside idle are ignored. Assumes LAT >= 1.
module adcif_conv_seq
    import adcif_pkg::*;
#(
    parameter int SAMP_W = 10,
    parameter int LAT    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              trig_sync,
    input  logic              abort,
    input  logic              sync_strobe,
    input  logic [SAMP_W-1:0] samp_word,
    output logic [SEL_W-1:0]  mux_sel,
    output logic [SAMP_W-1:0] res_q,
    output logic              valid_q,
    output logic              done_q
);
    localparam int CNT_W = $clog2(LAT + 1);

    conv_st_e          st;
    logic [CNT_W-1:0]  cnt;
    logic [SEL_W-1:0]  sel_q;
    logic [SAMP_W-1:0] hold_q;

    // Route the selector: the fresh code in idle, the held code otherwise.
    always_comb mux_sel = (st == ST_IDLE) ? trig_sel : sel_q;

    // Sequence one conversion: wait, sample, count, load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            sel_q   <= '0;
            hold_q  <= '0;
            res_q   <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (trig) begin
                        valid_q <= 1'b0;
                        sel_q   <= trig_sel;
                        if (trig_sync) begin
                            st <= ST_WAIT;
                        end else begin
                            hold_q <= samp_word;
                            cnt    <= CNT_W'(LAT);
                            st     <= ST_BUSY;
                        end
                    end
                end
                ST_WAIT: begin
                    if (abort) begin
                        st <= ST_IDLE;
                    end else if (sync_strobe) begin
                        hold_q <= samp_word;
                        cnt    <= CNT_W'(LAT);
                        st     <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (abort) begin
                        st <= ST_IDLE;
                    end else if (cnt == CNT_W'(1)) begin
                        res_q   <= hold_q;
                        valid_q <= 1'b1;
                        done_q  <= 1'b1;
                        st      <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && !abort && cnt != CNT_W'(1)) |=> (st == ST_BUSY && cnt == $past(cnt) - CNT_W'(1))); // R7
    AST_TRIG_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && trig) |=> !valid_q); // R8
    AST_RES_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(res_q)); // R8
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !sync_strobe && !abort) |=> (st == ST_WAIT)); // R9
    AST_BUSY_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && trig && cnt != CNT_W'(1)) |=> (st == ST_BUSY)); // R10
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && abort) |=> (st == ST_IDLE && !done_q)); // R11
endmodule

// File: rtl/adc_ctrl_if.sv
// Top of the multiplexed ADC control interface: control register, input
// selector, conversion sequencer and the read-data multiplexer.
// Assumes N_IN <= 8 (three-bit selector) and SAMP_W <= 15.
module adc_ctrl_if
    import adcif_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int SAMP_W = 10,
    parameter int LAT    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_addr,
    input  logic [15:0]            bus_wdata,
    output logic [15:0]            bus_rdata,
    input  logic [N_IN*SAMP_W-1:0] samp_in,
    input  logic                   sync_strobe,
    output logic                   conv_done
);
    logic [REG_W-1:0]  ctrl_q;
    logic              trig;
    logic [SEL_W-1:0]  trig_sel;
    logic              trig_sync;
    logic              abort;
    logic [SEL_W-1:0]  mux_sel;
    logic [SAMP_W-1:0] samp_word;
    logic [SAMP_W-1:0] res_q;
    logic              valid_q;

    adcif_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl_q    (ctrl_q),
        .trig      (trig),
        .trig_sel  (trig_sel),
        .trig_sync (trig_sync),
        .abort     (abort)
    );

    adcif_in_mux #(.N_IN(N_IN), .SAMP_W(SAMP_W), .SEL_W(SEL_W)) u_mux (
        .samp_in  (samp_in),
        .sel      (mux_sel),
        .samp_out (samp_word)
    );

    adcif_conv_seq #(.SAMP_W(SAMP_W), .LAT(LAT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig),
        .trig_sel    (trig_sel),
        .trig_sync   (trig_sync),
        .abort       (abort),
        .sync_strobe (sync_strobe),
        .samp_word   (samp_word),
        .mux_sel     (mux_sel),
        .res_q       (res_q),
        .valid_q     (valid_q),
        .done_q      (conv_done)
    );

    // Return the addressed register; unknown addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata = ctrl_q;
        end else if (bus_addr == DATA_ADDR) begin
            bus_rdata[SAMP_W-1:0] = res_q;
            bus_rdata[VALID_B]    = valid_q;
        end
    end

    AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> bus_rdata[VALID_B] || bus_addr != DATA_ADDR); // R3
endmodule

// File: tb/adc_ctrl_if_tb.sv
module adc_ctrl_if_tb;
    localparam int LAT    = 12;
    localparam int SAMP_W = 10;
    localparam logic [7:0] CA = 8'h66;
    localparam logic [7:0] DA = 8'h68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [79:0] samp_in;
    logic        sync_strobe = 1'b0;
    logic        conv_done;

    logic [9:0]  smp [8];
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    int          n_done = 0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (conv_done) n_done <= n_done + 1;

    always_comb begin
        for (int i = 0; i < 8; i++) samp_in[i*10 +: 10] = smp[i];
    end

    adc_ctrl_if u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .samp_in     (samp_in),
        .sync_strobe (sync_strobe),
        .conv_done   (conv_done)
    );

    function automatic logic [15:0] exp_data(input logic [9:0] v);
        return {1'b1, 5'b0, v};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // One write; called at a negedge, returns at the next negedge.
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic scramble();
        for (int i = 0; i < 8; i++) smp[i] = 10'($urandom);
    endtask

    // Full conversion with timing and result checks.
    task automatic run_conv(input int sel, input bit sync, input logic [15:0] extra, input int dly);
        logic [15:0] w;
        logic [15:0] d;
        logic [9:0]  expv;
        int          t0;
        int          nd;
        w = 16'h8000 | extra | 16'(sel << 2) | 16'(sync);
        wr(CA, w);
        wr(CA, w | 16'h0080);
        if (sync) begin
            nd = n_done;
            repeat (dly) @(negedge clk);
            rd(DA, d);
            chk("R9 waiting valid", {d[15], 15'b0}, 16'h0000);
            chk("R9 no early done", 16'(n_done - nd), 16'h0000);
            expv = smp[sel];
            sync_strobe = 1'b1;
            @(negedge clk);
            sync_strobe = 1'b0;
        end else begin
            expv = smp[sel];
        end
        t0 = cyc;
        scramble();
        rd(DA, d);
        chk("R8 valid cleared", {d[15], 15'b0}, 16'h0000);
        wait_until(t0 + LAT - 1);
        chk("R7 done not early", {15'b0, conv_done}, 16'h0000);
        @(negedge clk);
        chk("R7 done on time", {15'b0, conv_done}, 16'h0001);
        rd(DA, d);
        chk("R6 R3 result", d, exp_data(expv));
        @(negedge clk);
        chk("R7 done one cycle", {15'b0, conv_done}, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] keep;
        logic [9:0]  e;
        int          nd;
        int          t0;
        void'($urandom(32'd2024));
        scramble();
        repeat (3) @(negedge clk);
        rd(CA, d); chk("R1 ctrl reset", d, 16'h0000);
        rd(DA, d); chk("R1 data reset", d, 16'h0000);
        chk("R1 done reset", {15'b0, conv_done}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback mask and unmapped address
        wr(CA, 16'h7F7F);
        rd(CA, d); chk("R2 ctrl mask", d, 16'h003F);
        rd(8'h10, d); chk("R2 unmapped", d, 16'h0000);
        wr(CA, 16'h0000);

        // Directed conversions, no sync
        run_conv(5, 1'b0, 16'h0000, 0);
        run_conv(0, 1'b0, 16'h0022, 0);
        repeat (5) @(negedge clk);
        rd(DA, keep);
        chk("R8 valid held", {keep[15], 15'b0}, 16'h8000);

        // R4 repeated start without a 0 first
        nd = n_done;
        wr(CA, 16'h8080);
        repeat (LAT + 3) @(negedge clk);
        chk("R4 no retrigger", 16'(n_done - nd), 16'h0000);
        rd(DA, d); chk("R4 data unchanged", d, keep);

        // R5 start edge with enable clear
        wr(CA, 16'h0000);
        wr(CA, 16'h0080);
        rd(CA, d); chk("R5 start stored", d, 16'h0080);
        wr(CA, 16'h8080);
        repeat (LAT + 3) @(negedge clk);
        chk("R5 no conversion", 16'(n_done - nd), 16'h0000);
        rd(DA, d); chk("R5 data unchanged", d, keep);

        // R9 sync with long wait
        run_conv(3, 1'b1, 16'h0000, 2 * LAT);

        // R10 start edge while busy
        wr(CA, 16'h8000 | 16'(6 << 2));
        wr(CA, 16'h8080 | 16'(6 << 2));
        t0 = cyc;
        e = smp[6];
        scramble();
        wr(CA, 16'h8000 | 16'(1 << 2));
        wr(CA, 16'h8080 | 16'(1 << 2));
        wait_until(t0 + LAT - 1);
        chk("R10 done not early", {15'b0, conv_done}, 16'h0000);
        @(negedge clk);
        chk("R10 done original time", {15'b0, conv_done}, 16'h0001);
        rd(DA, d); chk("R10 original sample", d, exp_data(e));
        repeat (LAT + 2) @(negedge clk);
        chk("R10 no second done", {15'b0, conv_done}, 16'h0000);

        // R11 abort while running
        wr(CA, 16'h0000);
        nd = n_done;
        wr(CA, 16'h8000);
        wr(CA, 16'h8080);
        repeat (3) @(negedge clk);
        wr(CA, 16'h0000);
        repeat (LAT + 3) @(negedge clk);
        chk("R11 abort busy no done", 16'(n_done - nd), 16'h0000);
        rd(DA, d); chk("R11 valid clear", {d[15], 15'b0}, 16'h0000);

        // R11 abort while waiting for sync
        wr(CA, 16'h8001);
        wr(CA, 16'h8081);
        repeat (2) @(negedge clk);
        wr(CA, 16'h0000);
        sync_strobe = 1'b1;
        @(negedge clk);
        sync_strobe = 1'b0;
        repeat (LAT + 3) @(negedge clk);
        chk("R11 abort wait no done", 16'(n_done - nd), 16'h0000);

        // Random conversions
        for (int k = 0; k < 40; k++) begin
            wr(CA, 16'h0000);
            run_conv(int'($urandom_range(0, 7)), 1'($urandom), 16'($urandom) & 16'h0022,
                     int'($urandom_range(0, 5)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule